// File: doc/BRIEF.md
# Modified-Immediate Data-Processing Execute Stage

This block is the execute step for 32-bit data-processing operations whose second operand is an immediate that has already been expanded. Each cycle it takes a 4-bit operation code, a set-flags bit, the numbers of the source and destination registers, the source value, the expanded immediate with the carry bit from its expansion, and the current N, Z, C and V flags. It produces a result, a writeback enable with a destination index, the next flags and an undefined-operation indication. All outputs are registered, so they appear one clock after the inputs.

Some operation codes change meaning when a register number is 15. With the destination at 15 and the set-flags bit high, the bitwise-AND, exclusive-OR, add and subtract slots become flag-only forms that write no register. With the source at 15, the two OR slots become plain move and move-inverted. Add-with-carry, subtract-with-carry and reverse subtract each use the incoming carry in their own way. The pipeline feeds the block from its decoder and sends the registered outputs to register-file write and flag update.

Top module: `miexec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are zero after that edge.
- R2: Outputs are registered. The values for the inputs present at clock edge k appear after edge k, and `wr_idx` equals the `rd_idx` sampled at that edge.
- R3: The logical codes compute, with A the source value and I the immediate: code 0x0 A&I, 0x1 A&~I, 0x2 A|I, 0x3 A|~I, 0x4 A^I. A defined, non-flag-only operation sets `wr_en` to 1.
- R4: When `rn_idx` is 15, code 0x2 returns I and code 0x3 returns ~I, whatever A is.
- R5: Code 0x8 returns A+I and code 0xa returns A+I+C, where C is `flags_in[1]`. Their carry is the carry out of bit 31. Their overflow is set when both addends have the same sign and the sum has the other sign.
- R6: Code 0xd returns A-I, code 0xb returns A-I-(1-C) and code 0xe returns I-A. For these, C is 1 when no borrow occurs. V is set when the operands differ in sign and the result's sign differs from the minuend's (A, or I for 0xe).
- R7: When `rd_idx` is 15 and `set_flags` is 1, codes 0x0, 0x4, 0x8 and 0xd compute their value and update the flags, but `wr_en` is 0.
- R8: The flag vector is {N,Z,C,V} at bits 3..0. When flags update, N is result bit 31 and Z is 1 exactly when the result is zero. Flags update only when `set_flags` is 1 or a flag-only form from R7 is selected. Otherwise `flags_out` equals `flags_in`.
- R9: When the logical codes (including the move forms) update flags, C takes `imm_carry` and V keeps `flags_in[0]`.
- R10: Codes 0x5, 0x6, 0x7, 0x9, 0xc and 0xf are undefined. So are codes 0x0, 0x4, 0x8 and 0xd with `rd_idx` 15 and `set_flags` 0. An undefined operation sets `undef_out` to 1, `wr_en` to 0, `res_out` to 0, and `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation code |
| set_flags | input | 1 | Flag update request |
| rn_idx | input | 4 | Source register number |
| rd_idx | input | 4 | Destination register number |
| rn_val | input | 32 | Source operand value |
| imm_val | input | 32 | Expanded immediate |
| imm_carry | input | 1 | Carry produced by immediate expansion |
| flags_in | input | 4 | Current {N,Z,C,V} |
| res_out | output | 32 | Registered result |
| wr_en | output | 1 | Registered writeback enable |
| wr_idx | output | 4 | Registered destination index |
| flags_out | output | 4 | Registered next {N,Z,C,V} |
| undef_out | output | 1 | Registered undefined-operation flag |

## Verification
There is no internal state apart from the output register, so a fault in decoding or arithmetic shows at the ports on the cycle after the offending inputs. A wrong slot remap shows as a wrong `wr_en`, a wrong result or a wrong `undef_out`. A wrong carry-in or borrow convention shows in `res_out` bit 0 or in `flags_out` bits 1..0. The vectors pair each code with operands that hit carry-out, signed overflow and zero results, so an operand-swap or inversion error is visible in one cycle.

// File: rtl/miexec_pkg.sv
package miexec_pkg;

  localparam int FLAG_W = 4;

  localparam logic [3:0] OPC_AND = 4'h0;
  localparam logic [3:0] OPC_BIC = 4'h1;
  localparam logic [3:0] OPC_ORR = 4'h2;
  localparam logic [3:0] OPC_ORN = 4'h3;
  localparam logic [3:0] OPC_EOR = 4'h4;
  localparam logic [3:0] OPC_ADD = 4'h8;
  localparam logic [3:0] OPC_ADC = 4'ha;
  localparam logic [3:0] OPC_SBC = 4'hb;
  localparam logic [3:0] OPC_SUB = 4'hd;
  localparam logic [3:0] OPC_RSB = 4'he;

  typedef enum logic [1:0] {CLS_NONE, CLS_LOGIC, CLS_ARITH} op_class_e;

  typedef enum logic [2:0] {
    LF_AND, LF_BIC, LF_ORR, LF_ORN, LF_EOR, LF_MOV, LF_MVN
  } logic_fn_e;

  typedef enum logic [2:0] {
    AF_ADD, AF_ADC, AF_SUB, AF_SBC, AF_RSB
  } arith_fn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef struct packed {
    op_class_e cls;
    logic_fn_e lfn;
    arith_fn_e afn;
    logic      wb;
    logic      fl_en;
    logic      undef;
  } dec_t;

endpackage

// File: rtl/miexec_decode.sv
module miexec_decode
  import miexec_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [3:0]       op_code,
  input  logic             set_flags,
  input  logic [IDX_W-1:0] rn_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output dec_t             dec
);

  localparam logic [IDX_W-1:0] PC_IDX = '1;

  logic rn_is_pc;
  logic rd_is_pc;
  logic cmp_slot;

  assign rn_is_pc = (rn_idx == PC_IDX);
  assign rd_is_pc = (rd_idx == PC_IDX);

  always_comb begin
    dec          = '0;
    dec.cls      = CLS_NONE;
    dec.lfn      = LF_AND;
    dec.afn      = AF_ADD;
    cmp_slot     = 1'b0;
    case (op_code)
      OPC_AND: begin dec.cls = CLS_LOGIC; dec.lfn = LF_AND; cmp_slot = 1'b1; end
      OPC_BIC: begin dec.cls = CLS_LOGIC; dec.lfn = LF_BIC; end
      OPC_ORR: begin dec.cls = CLS_LOGIC; dec.lfn = rn_is_pc ? LF_MOV : LF_ORR; end
      OPC_ORN: begin dec.cls = CLS_LOGIC; dec.lfn = rn_is_pc ? LF_MVN : LF_ORN; end
      OPC_EOR: begin dec.cls = CLS_LOGIC; dec.lfn = LF_EOR; cmp_slot = 1'b1; end
      OPC_ADD: begin dec.cls = CLS_ARITH; dec.afn = AF_ADD; cmp_slot = 1'b1; end
      OPC_ADC: begin dec.cls = CLS_ARITH; dec.afn = AF_ADC; end
      OPC_SBC: begin dec.cls = CLS_ARITH; dec.afn = AF_SBC; end
      OPC_SUB: begin dec.cls = CLS_ARITH; dec.afn = AF_SUB; cmp_slot = 1'b1; end
      OPC_RSB: begin dec.cls = CLS_ARITH; dec.afn = AF_RSB; end
      default: dec.cls = CLS_NONE;
    endcase

    if (dec.cls == CLS_NONE) begin
      dec.undef = 1'b1;
    end else if (cmp_slot && rd_is_pc) begin
      if (set_flags) dec.fl_en = 1'b1;
      else           dec.undef = 1'b1;
    end else begin
      dec.wb    = 1'b1;
      dec.fl_en = set_flags;
    end
  end

endmodule

// File: rtl/miexec_logic.sv
module miexec_logic
  import miexec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opi,
  input  logic_fn_e         fn,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    case (fn)
      LF_AND:  res = opa & opi;
      LF_BIC:  res = opa & ~opi;
      LF_ORR:  res = opa | opi;
      LF_ORN:  res = opa | ~opi;
      LF_EOR:  res = opa ^ opi;
      LF_MOV:  res = opi;
      LF_MVN:  res = ~opi;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/miexec_adder.sv
module miexec_adder
  import miexec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opi,
  input  arith_fn_e         fn,
  input  logic              c_in,
  output logic [DATA_W-1:0] sum,
  output logic              c_out,
  output logic              v_out
);

  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] x;
  logic [DATA_W-1:0] y;
  logic              cin;
  logic [SUM_W-1:0]  full;

  // One adder: subtraction is x + ~y + 1, so carry out means no borrow.
  always_comb begin
    case (fn)
      AF_ADD:  begin x = opa; y = opi;  cin = 1'b0; end
      AF_ADC:  begin x = opa; y = opi;  cin = c_in; end
      AF_SUB:  begin x = opa; y = ~opi; cin = 1'b1; end
      AF_SBC:  begin x = opa; y = ~opi; cin = c_in; end
      AF_RSB:  begin x = opi; y = ~opa; cin = 1'b1; end
      default: begin x = opa; y = opi;  cin = 1'b0; end
    endcase
  end

  assign full  = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  assign sum   = full[DATA_W-1:0];
  assign c_out = full[DATA_W];
  assign v_out = (x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);

endmodule

// File: rtl/miexec_unit.sv
module miexec_unit
  import miexec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_code,
  input  logic              set_flags,
  input  logic [IDX_W-1:0]  rn_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] imm_val,
  input  logic              imm_carry,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] res_out,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [FLAG_W-1:0] flags_out,
  output logic              undef_out
);

  localparam logic [IDX_W-1:0] PC_IDX = '1;

  dec_t              dec;
  nzcv_t             fl_cur;
  nzcv_t             fl_nxt;
  logic [DATA_W-1:0] lres;
  logic [DATA_W-1:0] ares;
  logic              a_c;
  logic              a_v;
  logic [DATA_W-1:0] res_c;
  logic              primed_q;

  assign fl_cur = nzcv_t'(flags_in);

  miexec_decode #(.IDX_W(IDX_W)) u_dec (
    .op_code  (op_code),
    .set_flags(set_flags),
    .rn_idx   (rn_idx),
    .rd_idx   (rd_idx),
    .dec      (dec)
  );

  miexec_logic #(.DATA_W(DATA_W)) u_logic (
    .opa(rn_val),
    .opi(imm_val),
    .fn (dec.lfn),
    .res(lres)
  );

  miexec_adder #(.DATA_W(DATA_W)) u_add (
    .opa  (rn_val),
    .opi  (imm_val),
    .fn   (dec.afn),
    .c_in (fl_cur.c),
    .sum  (ares),
    .c_out(a_c),
    .v_out(a_v)
  );

  always_comb begin
    if (dec.undef)                res_c = '0;
    else if (dec.cls == CLS_ARITH) res_c = ares;
    else                           res_c = lres;
  end

  always_comb begin
    fl_nxt = fl_cur;
    if (dec.fl_en) begin
      fl_nxt.n = res_c[DATA_W-1];
      fl_nxt.z = (res_c == '0);
      if (dec.cls == CLS_ARITH) begin
        fl_nxt.c = a_c;
        fl_nxt.v = a_v;
      end else begin
        fl_nxt.c = imm_carry;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      flags_out <= '0;
      undef_out <= 1'b0;
      primed_q  <= 1'b0;
    end else begin
      res_out   <= res_c;
      wr_en     <= dec.wb;
      wr_idx    <= rd_idx;
      flags_out <= fl_nxt;
      undef_out <= dec.undef;
      primed_q  <= 1'b1;
    end
  end

  // R10
  undef_nowb_chk: assert property (@(posedge clk) disable iff (rst)
    undef_out |-> (!wr_en && res_out == '0));

  // R2
  idx_follow_chk: assert property (@(posedge clk) disable iff (rst)
    primed_q |-> (wr_idx == $past(rd_idx)));

  // R7
  cmp_nowb_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(set_flags && rd_idx == PC_IDX &&
      (op_code == OPC_AND || op_code == OPC_EOR || op_code == OPC_ADD || op_code == OPC_SUB)))
    |-> !wr_en);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(!set_flags && rd_idx != PC_IDX)) |-> (flags_out == $past(flags_in)));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(set_flags) && !undef_out) |-> (flags_out[2] == (res_out == '0)));

  // R9
  v_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(set_flags && op_code <= OPC_EOR)) |-> (flags_out[0] == $past(flags_in[0])));

endmodule

// File: tb/test_miexec_unit.sv
module test_miexec_unit;

  typedef struct packed {
    logic [3:0]  op;
    logic        s;
    logic [3:0]  rn;
    logic [3:0]  rd;
    logic [31:0] a;
    logic [31:0] i;
    logic        ic;
    logic [3:0]  fl;
    logic [31:0] e_res;
    logic        e_we;
    logic [3:0]  e_fl;
    logic        e_und;
  } vec_t;

  localparam int NV = 25;
  localparam logic [119:0] TBL [NV] = '{
    {4'h0,1'b0,4'd1,4'd2,32'hF0F000FF,32'h0FF00F0F,1'b0,4'b0000, 32'h00F0000F,1'b1,4'b0000,1'b0}, // R3 and
    {4'h1,1'b1,4'd1,4'd3,32'hFFFF0000,32'hFFFFFFFF,1'b1,4'b0001, 32'h00000000,1'b1,4'b0111,1'b0}, // R3 R9 bic
    {4'h2,1'b1,4'd4,4'd5,32'h80000000,32'h00000001,1'b0,4'b0010, 32'h80000001,1'b1,4'b1000,1'b0}, // R3 R9 orr
    {4'h2,1'b0,4'd15,4'd6,32'hDEADBEEF,32'h12345678,1'b0,4'b1111, 32'h12345678,1'b1,4'b1111,1'b0}, // R4 mov
    {4'h3,1'b1,4'd15,4'd7,32'h00000000,32'h000000FF,1'b1,4'b0000, 32'hFFFFFF00,1'b1,4'b1010,1'b0}, // R4 mvn
    {4'h3,1'b0,4'd1,4'd8,32'h0000000F,32'hFFFFFF00,1'b0,4'b0101, 32'h000000FF,1'b1,4'b0101,1'b0}, // R3 orn
    {4'h4,1'b1,4'd1,4'd9,32'hAAAAAAAA,32'hAAAAAAAA,1'b0,4'b1001, 32'h00000000,1'b1,4'b0101,1'b0}, // R3 R8 eor
    {4'h8,1'b1,4'd1,4'd10,32'h7FFFFFFF,32'h00000001,1'b0,4'b0000, 32'h80000000,1'b1,4'b1001,1'b0}, // R5 ovf
    {4'h8,1'b1,4'd1,4'd10,32'hFFFFFFFF,32'h00000001,1'b0,4'b0000, 32'h00000000,1'b1,4'b0110,1'b0}, // R5 carry
    {4'ha,1'b1,4'd1,4'd4,32'h00000001,32'h00000002,1'b0,4'b0010, 32'h00000004,1'b1,4'b0000,1'b0}, // R5 adc c=1
    {4'ha,1'b0,4'd1,4'd4,32'h00000001,32'h00000002,1'b0,4'b0000, 32'h00000003,1'b1,4'b0000,1'b0}, // R5 adc c=0
    {4'hb,1'b1,4'd1,4'd4,32'h00000005,32'h00000003,1'b0,4'b0000, 32'h00000001,1'b1,4'b0010,1'b0}, // R6 sbc c=0
    {4'hb,1'b1,4'd1,4'd4,32'h00000005,32'h00000003,1'b0,4'b0010, 32'h00000002,1'b1,4'b0010,1'b0}, // R6 sbc c=1
    {4'hd,1'b1,4'd1,4'd11,32'h00000003,32'h00000005,1'b0,4'b0000, 32'hFFFFFFFE,1'b1,4'b1000,1'b0}, // R6 borrow
    {4'hd,1'b1,4'd1,4'd11,32'h80000000,32'h00000001,1'b0,4'b0000, 32'h7FFFFFFF,1'b1,4'b0011,1'b0}, // R6 ovf
    {4'he,1'b1,4'd1,4'd12,32'h00000001,32'h00000000,1'b0,4'b0000, 32'hFFFFFFFF,1'b1,4'b1000,1'b0}, // R6 rsb
    {4'he,1'b1,4'd1,4'd12,32'h0000000A,32'h0000000A,1'b0,4'b0000, 32'h00000000,1'b1,4'b0110,1'b0}, // R6 rsb eq
    {4'h0,1'b1,4'd1,4'd15,32'h000000F0,32'h0000000F,1'b1,4'b0001, 32'h00000000,1'b0,4'b0111,1'b0}, // R7 tst
    {4'h4,1'b1,4'd1,4'd15,32'h80000000,32'h00000000,1'b0,4'b0000, 32'h80000000,1'b0,4'b1000,1'b0}, // R7 teq
    {4'h8,1'b1,4'd1,4'd15,32'hFFFFFFFF,32'h00000001,1'b0,4'b0000, 32'h00000000,1'b0,4'b0110,1'b0}, // R7 cmn
    {4'hd,1'b1,4'd1,4'd15,32'h00000005,32'h00000005,1'b0,4'b1000, 32'h00000000,1'b0,4'b0110,1'b0}, // R7 cmp
    {4'h5,1'b1,4'd1,4'd2,32'h00000001,32'h00000001,1'b0,4'b1010, 32'h00000000,1'b0,4'b1010,1'b1}, // R10 op5
    {4'hf,1'b1,4'd1,4'd2,32'h00000001,32'h00000001,1'b0,4'b0101, 32'h00000000,1'b0,4'b0101,1'b1}, // R10 opf
    {4'hd,1'b0,4'd1,4'd15,32'h00000009,32'h00000001,1'b0,4'b0011, 32'h00000000,1'b0,4'b0011,1'b1}, // R10 cmp S0
    {4'h0,1'b0,4'd1,4'd15,32'h00000009,32'h00000001,1'b1,4'b1100, 32'h00000000,1'b0,4'b1100,1'b1}  // R10 tst S0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  rn_idx = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rn_val = '0;
  logic [31:0] imm_val = '0;
  logic        imm_carry = 1'b0;
  logic [3:0]  flags_in = '0;
  logic [31:0] res_out;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [3:0]  flags_out;
  logic        undef_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  miexec_unit i_miexec_unit (
    .clk(clk), .rst(rst), .op_code(op_code), .set_flags(set_flags),
    .rn_idx(rn_idx), .rd_idx(rd_idx), .rn_val(rn_val), .imm_val(imm_val),
    .imm_carry(imm_carry), .flags_in(flags_in), .res_out(res_out),
    .wr_en(wr_en), .wr_idx(wr_idx), .flags_out(flags_out), .undef_out(undef_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op_code = v.op; set_flags = v.s; rn_idx = v.rn; rd_idx = v.rd;
    rn_val = v.a; imm_val = v.i; imm_carry = v.ic; flags_in = v.fl;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset clears every output
    drive(vec_t'(TBL[7]));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 res", {32'h0, res_out}, 64'h0);
    chk("R1 ctl", {56'h0, wr_en, wr_idx, undef_out}, 64'h0);
    chk("R1 flags", {60'h0, flags_out}, 64'h0);
    rst = 1'b0;

    // Table walk: drive at negedge, result after next posedge
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = vec_t'(TBL[k]);
      drive(v);
      @(negedge clk);
      chk($sformatf("R3-10 vec%0d res", k), {32'h0, res_out}, {32'h0, v.e_res});
      chk($sformatf("R7 R10 vec%0d wr_en", k), {63'h0, wr_en}, {63'h0, v.e_we});
      chk($sformatf("R8 vec%0d flags", k), {60'h0, flags_out}, {60'h0, v.e_fl});
      chk($sformatf("R10 vec%0d undef", k), {63'h0, undef_out}, {63'h0, v.e_und});
      chk($sformatf("R2 vec%0d idx", k), {60'h0, wr_idx}, {60'h0, v.rd});
    end

    // R2: output holds until the next edge, then follows new inputs
    drive(vec_t'(TBL[0]));
    @(negedge clk);
    drive(vec_t'(TBL[3]));
    #1;
    chk("R2 hold before edge", {32'h0, res_out}, 64'h00F0000F);
    @(negedge clk);
    chk("R2 after edge", {32'h0, res_out}, 64'h12345678);

    // R4: move ignores a nonzero source value
    op_code = 4'h3; set_flags = 1'b0; rn_idx = 4'd15; rd_idx = 4'd1;
    rn_val = 32'hFFFFFFFF; imm_val = 32'h0F0F0F0F; flags_in = 4'b0000;
    @(negedge clk);
    chk("R4 mvn ignores A", {32'h0, res_out}, 64'hF0F0F0F0);

    // R1: reset mid-stream clears again
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset", {27'h0, res_out, wr_en, flags_out}, 64'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule